// File: doc/BRIEF.md
# SMBus Clock Generator and Bus Timeout Monitor

This block sits next to an SMBus controller and handles the clock side of the link. An 8-bit control register holds three live bits: a soft reset, a clock enable and a halve-rate select. Together they choose whether a serial clock is produced at all, and at which of two rates (100 kHz or 50 kHz with the default parameters). The generated clock has a 50 % duty cycle. A change of rate is applied only at the start of a new period, so no short pulse appears.

The same block watches the synchronized clock and data lines of the bus. It raises a sticky timeout status bit when the clock line stays low past a limit, and it signals an idle bus once both lines have stayed high past a maximum clock-high time. A bus that stops with both lines high is legal and never counts as a timeout. While the soft-reset bit holds 1, every piece of logic except the control register stays cleared.

Three state machines do the work. The clock generator has states SG_OFF, SG_HIGH and SG_LOW. Its transitions are: off to high when enabled, high to low at the end of a half period, low to high at the end of a half period (this is where the rate select is latched), and any state to off when disabled or in soft reset. The low-time watcher has states LT_WAIT, LT_COUNT and LT_TRIP. Its transitions are: wait to count on a low sample, count back to wait on a high sample, count to trip when the limit is passed (this sets the status bit), and trip to wait on a high sample. The idle detector has states ID_BUSY, ID_COUNT and ID_IDLE. Its transitions are: busy to count when both lines are high, count to idle when the limit is passed, and count or idle back to busy when either line is low. The watcher and the detector are held in their first state while the enable bit is 0 or the soft reset is active.

Top module: `smbc_clkmon`

## Requirements
- R1: After the asynchronous reset, the control readback is 0x00, scl_out is 1, te_stat is 0 and bus_idle is 0.
- R2: Only control bits 7 (soft reset), 2 (halve rate) and 1 (clock enable) are stored. Bits 6 to 3 and bit 0 always read 0, and writes to them have no effect.
- R3: While the enable bit is 0 or the soft reset is 1, scl_out is 1 from the next cycle on.
- R4: With enable 1 and halve 0, scl_out is high for SCL_HALF cycles and low for SCL_HALF cycles.
- R5: With halve 1, each phase lasts 2*SCL_HALF cycles. The halve bit is latched only when a high phase begins, so every low phase equals the high phase before it and is either SCL_HALF or 2*SCL_HALF long.
- R6: te_stat sets when scl_in is sampled low on TIMEOUT_CYC+1 consecutive cycles. A low run of exactly TIMEOUT_CYC samples leaves it clear.
- R7: te_stat stays set until a te_clr pulse clears it. In a cycle where a set and a clear coincide, the set wins. A low period sets it only once.
- R8: bus_idle rises after scl_in and sda_in are both sampled high on IDLE_CYC+1 consecutive cycles. It falls the cycle after either line is sampled low.
- R9: A clock line parked high for any length of time never sets te_stat.
- R10: While the enable bit is 0, the low-time and idle counters do not run: a low run never sets te_stat and bus_idle stays 0.
- R11: While the soft-reset bit is 1, te_stat and bus_idle are cleared and held at 0, and scl_out is held high. The control register remains writable so the bit can be cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data (bit 7 soft reset, bit 2 halve rate, bit 1 enable) |
| ctl_rdata | output | 8 | Control register readback |
| te_clr | input | 1 | Write-one pulse that clears the timeout status |
| scl_in | input | 1 | Synchronized clock line sample |
| sda_in | input | 1 | Synchronized data line sample |
| scl_out | output | 1 | Generated serial clock level |
| te_stat | output | 1 | Sticky clock-low timeout status |
| bus_idle | output | 1 | Bus idle flag |

## Verification
Some properties are checked by assertions on every cycle:
- the clock output is parked high whenever the enable is off or the soft reset is on;
- the half-period counter stays in range;
- a timeout can only rise after a low sample of the clock line;
- a high sample of the clock line always rearms the low-time watcher;
- a low sample on either line drops the idle flag;
- soft reset clears the status bit.

Other behaviour can only be shown by the bench scenarios. These are the exact threshold of the timeout and idle counts, the set-over-clear priority, the measured phase lengths at both rates, and the match between each low phase and the high phase before it while the rate select is toggled at random points.

// File: rtl/smbc_pkg.sv
package smbc_pkg;

    typedef enum logic [1:0] {SG_OFF, SG_HIGH, SG_LOW} sg_state_e;
    typedef enum logic [1:0] {LT_WAIT, LT_COUNT, LT_TRIP} lt_state_e;
    typedef enum logic [1:0] {ID_BUSY, ID_COUNT, ID_IDLE} id_state_e;

    localparam int CTL_W       = 8;
    localparam int CTL_RST_BIT = 7;
    localparam int CTL_DIV_BIT = 2;
    localparam int CTL_EN_BIT  = 1;
    localparam logic [CTL_W-1:0] CTL_MASK = 8'h86;

endpackage

// File: rtl/smbc_sclgen.sv
module smbc_sclgen
    import smbc_pkg::*;
#(
    parameter int SCL_HALF = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    input  logic en,
    input  logic div,
    output logic scl_out
);
    localparam int CW = $clog2(2 * SCL_HALF + 1);

    sg_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic        div_q, div_d;
    logic [CW-1:0] half_w;
    logic        phase_end;

    assign half_w    = div_q ? CW'(2 * SCL_HALF) : CW'(SCL_HALF);
    assign phase_end = (cnt_q == half_w - CW'(1));

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + CW'(1);
        div_d   = div_q;
        if (srst || !en) begin
            state_d = SG_OFF;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                SG_OFF: begin
                    state_d = SG_HIGH;
                    cnt_d   = '0;
                    div_d   = div;
                end
                SG_HIGH: begin
                    if (phase_end) begin
                        state_d = SG_LOW;
                        cnt_d   = '0;
                    end
                end
                SG_LOW: begin
                    if (phase_end) begin
                        state_d = SG_HIGH;
                        cnt_d   = '0;
                        div_d   = div;
                    end
                end
                default: begin
                    state_d = SG_OFF;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SG_OFF;
            cnt_q   <= '0;
            div_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            div_q   <= div_d;
        end
    end

    always_comb begin
        scl_out = (state_q != SG_LOW);
    end

    // R3
    sg_park_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srst || !en) |=> scl_out);

    // R5
    sg_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SG_OFF) |-> (cnt_q < half_w));

endmodule

// File: rtl/smbc_lowtimer.sv
module smbc_lowtimer
    import smbc_pkg::*;
#(
    parameter int TIMEOUT_CYC = 2_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    input  logic run,
    input  logic scl_in,
    input  logic te_clr,
    output logic te
);
    localparam int CW = $clog2(TIMEOUT_CYC + 2);

    lt_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          te_set;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        te_set  = 1'b0;
        if (srst || !run) begin
            state_d = LT_WAIT;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                LT_WAIT: begin
                    if (!scl_in) begin
                        state_d = LT_COUNT;
                        cnt_d   = CW'(1);
                    end
                end
                LT_COUNT: begin
                    if (scl_in) begin
                        state_d = LT_WAIT;
                        cnt_d   = '0;
                    end else if (cnt_q == CW'(TIMEOUT_CYC)) begin
                        state_d = LT_TRIP;
                        te_set  = 1'b1;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                LT_TRIP: begin
                    if (scl_in) begin
                        state_d = LT_WAIT;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = LT_WAIT;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LT_WAIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       te <= 1'b0;
        else if (srst)    te <= 1'b0;
        else if (te_set)  te <= 1'b1;
        else if (te_clr)  te <= 1'b0;
    end

    // R6
    lt_rise_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(te) |-> !$past(scl_in));

    // R9
    lt_high_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_in |=> (state_q == LT_WAIT));

    // R11
    lt_srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> !te);

endmodule

// File: rtl/smbc_idledet.sv
module smbc_idledet
    import smbc_pkg::*;
#(
    parameter int IDLE_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    input  logic run,
    input  logic scl_in,
    input  logic sda_in,
    output logic bus_idle
);
    localparam int CW = $clog2(IDLE_CYC + 2);

    id_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          both_high;

    assign both_high = scl_in && sda_in;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (srst || !run) begin
            state_d = ID_BUSY;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ID_BUSY: begin
                    if (both_high) begin
                        state_d = ID_COUNT;
                        cnt_d   = CW'(1);
                    end
                end
                ID_COUNT: begin
                    if (!both_high) begin
                        state_d = ID_BUSY;
                        cnt_d   = '0;
                    end else if (cnt_q == CW'(IDLE_CYC)) begin
                        state_d = ID_IDLE;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                ID_IDLE: begin
                    if (!both_high) begin
                        state_d = ID_BUSY;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = ID_BUSY;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ID_BUSY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        bus_idle = (state_q == ID_IDLE);
    end

    // R8
    id_low_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_in || !sda_in) |=> !bus_idle);

    // R10
    id_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !bus_idle);

endmodule

// File: rtl/smbc_clkmon.sv
module smbc_clkmon
    import smbc_pkg::*;
#(
    parameter int CLK_HZ      = 100_000_000,
    parameter int SCL_HALF    = CLK_HZ / 200_000,
    parameter int TIMEOUT_CYC = CLK_HZ / 40,
    parameter int IDLE_CYC    = CLK_HZ / 20_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_rdata,
    input  logic       te_clr,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_out,
    output logic       te_stat,
    output logic       bus_idle
);
    logic [CTL_W-1:0] ctl_q;
    logic             srst;
    logic             en;
    logic             div;
    logic             run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_we) ctl_q <= ctl_wdata & CTL_MASK;
    end

    assign ctl_rdata = ctl_q;
    assign srst      = ctl_q[CTL_RST_BIT];
    assign en        = ctl_q[CTL_EN_BIT];
    assign div       = ctl_q[CTL_DIV_BIT];
    assign run       = en && !srst;

    smbc_sclgen #(.SCL_HALF(SCL_HALF)) u_sclgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .srst    (srst),
        .en      (en),
        .div     (div),
        .scl_out (scl_out)
    );

    smbc_lowtimer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_lowtimer (
        .clk    (clk),
        .rst_n  (rst_n),
        .srst   (srst),
        .run    (run),
        .scl_in (scl_in),
        .te_clr (te_clr),
        .te     (te_stat)
    );

    smbc_idledet #(.IDLE_CYC(IDLE_CYC)) u_idledet (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (srst),
        .run      (run),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .bus_idle (bus_idle)
    );

    // R2
    top_rsvd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (ctl_rdata[6:3] == 4'b0) && (ctl_rdata[0] == 1'b0));

endmodule

// File: tb/test_smbc_clkmon.sv
module test_smbc_clkmon;
    localparam int H   = 4;
    localparam int TO  = 40;
    localparam int IDL = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic       te_clr = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       scl_out, te_stat, bus_idle;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    smbc_clkmon #(.SCL_HALF(H), .TIMEOUT_CYC(TO), .IDLE_CYC(IDL)) i_smbc_clkmon (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .te_clr(te_clr), .scl_in(scl_in), .sda_in(sda_in),
        .scl_out(scl_out), .te_stat(te_stat), .bus_idle(bus_idle)
    );

    // Reference state built from the requirements
    int lo_run, hi_run;
    bit te_m, idle_m, m_rst, m_en, m_div;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_run = 0; hi_run = 0; te_m = 0; idle_m = 0;
            m_rst = 0; m_en = 0; m_div = 0;
        end else begin
            if (m_rst) begin
                lo_run = 0; hi_run = 0; te_m = 0; idle_m = 0;
            end else if (!m_en) begin
                lo_run = 0; hi_run = 0; idle_m = 0;
                if (te_clr) te_m = 0;
            end else begin
                if (!scl_in) begin
                    lo_run = lo_run + 1;
                    if (lo_run == TO + 1) te_m = 1;
                    else if (te_clr) te_m = 0;
                end else begin
                    lo_run = 0;
                    if (te_clr) te_m = 0;
                end
                if (scl_in && sda_in) begin
                    hi_run = hi_run + 1;
                    idle_m = (hi_run > IDL);
                end else begin
                    hi_run = 0;
                    idle_m = 0;
                end
            end
            if (ctl_we) begin
                m_rst = ctl_wdata[7]; m_div = ctl_wdata[2]; m_en = ctl_wdata[1];
            end
        end
    end

    // Phase monitor for R5
    bit mon_on = 0;
    bit mon_sync = 0;
    bit mon_lvl = 1;
    int run_len = 0;
    int hi_len = 0;
    int mon_bad = 0;
    int mon_n = 0;

    always @(negedge clk) begin
        if (!mon_on) begin
            mon_sync = 0;
            run_len  = 0;
            mon_lvl  = scl_out;
        end else begin
            if (scl_out == mon_lvl) begin
                run_len = run_len + 1;
            end else begin
                if (mon_sync && mon_lvl) hi_len = run_len;
                if (mon_sync && !mon_lvl) begin
                    mon_n = mon_n + 1;
                    if (run_len != hi_len || !(run_len == H || run_len == 2 * H))
                        mon_bad = mon_bad + 1;
                end
                if (!mon_lvl) mon_sync = 1;
                run_len = 1;
                mon_lvl = scl_out;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        ctl_we = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic hold(input bit s, input bit d, input int n);
        scl_in = s; sda_in = d;
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        te_clr = 1'b1;
        @(negedge clk);
        te_clr = 1'b0;
    endtask

    task automatic measure(output int lo_len, output int hi_l);
        int guard;
        guard = 0;
        while (scl_out !== 1'b0 && guard < 200) begin @(negedge clk); guard++; end
        lo_len = 0;
        while (scl_out === 1'b0 && guard < 400) begin @(negedge clk); lo_len++; guard++; end
        hi_l = 0;
        while (scl_out === 1'b1 && guard < 600) begin @(negedge clk); hi_l++; guard++; end
    endtask

    function automatic logic [7:0] rd_expect(input logic [7:0] w);
        return w & 8'h86;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int lo_l, hi_l, bad, seed;
        seed = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1
        chk(ctl_rdata == 8'h00, "R1 rdata", ctl_rdata, 0);
        chk(scl_out == 1'b1, "R1 scl_out", scl_out, 1);
        chk(te_stat == 1'b0, "R1 te_stat", te_stat, 0);
        chk(bus_idle == 1'b0, "R1 bus_idle", bus_idle, 0);

        // R3: disabled clock stays high
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (scl_out !== 1'b1) bad++;
        end
        chk(bad == 0, "R3 scl parked", bad, 0);

        // R10: counters frozen while disabled
        hold(0, 1, TO + 20);
        chk(te_stat == 1'b0, "R10 te while disabled", te_stat, 0);
        hold(1, 1, IDL + 10);
        chk(bus_idle == 1'b0, "R10 idle while disabled", bus_idle, 0);

        // R2: reserved bits
        wr(8'hFF);
        chk(ctl_rdata == 8'h86, "R2 rdata all ones", ctl_rdata, 8'h86);
        wr(8'h79);
        chk(ctl_rdata == rd_expect(8'h79), "R2 rdata reserved only", ctl_rdata, 0);
        wr(8'h02);

        // R6: threshold of the low-time count
        hold(1, 1, 3);
        hold(0, 1, TO);
        chk(te_stat == 1'b0, "R6 exactly limit", te_stat, 0);
        hold(1, 1, 2);
        hold(0, 1, TO + 1);
        chk(te_stat == 1'b1, "R6 limit plus one", te_stat, 1);

        // R7: sticky, clear, set wins
        hold(1, 1, 5);
        chk(te_stat == 1'b1, "R7 sticky", te_stat, 1);
        pulse_clr();
        chk(te_stat == 1'b0, "R7 cleared", te_stat, 0);
        hold(0, 1, TO);
        pulse_clr();
        chk(te_stat == 1'b1, "R7 set wins", te_stat, 1);
        hold(0, 1, 3);
        pulse_clr();
        hold(0, 1, TO);
        chk(te_stat == 1'b0, "R7 once per low period", te_stat, 0);
        scl_in = 1'b1;
        pulse_clr();

        // R9: parked high clock
        hold(1, 1, 300);
        chk(te_stat == 1'b0, "R9 parked high no timeout", te_stat, 0);
        chk(bus_idle == 1'b1, "R9 parked high idle", bus_idle, 1);

        // R8: idle threshold
        hold(1, 0, 1);
        chk(bus_idle == 1'b0, "R8 sda low drops idle", bus_idle, 0);
        hold(1, 1, IDL);
        chk(bus_idle == 1'b0, "R8 exactly limit", bus_idle, 0);
        hold(1, 1, 1);
        chk(bus_idle == 1'b1, "R8 limit plus one", bus_idle, 1);
        hold(0, 1, 1);
        chk(bus_idle == 1'b0, "R8 scl low drops idle", bus_idle, 0);

        // R11: soft reset
        hold(0, 1, TO + 1);
        chk(te_stat == 1'b1, "R11 te before soft reset", te_stat, 1);
        wr(8'h86);
        chk(ctl_rdata == 8'h86, "R11 rdata", ctl_rdata, 8'h86);
        hold(0, 1, TO + 5);
        chk(te_stat == 1'b0, "R11 te held clear", te_stat, 0);
        chk(scl_out == 1'b1, "R11 scl high", scl_out, 1);
        hold(1, 1, IDL + 5);
        chk(bus_idle == 1'b0, "R11 idle held clear", bus_idle, 0);
        wr(8'h02);
        chk(ctl_rdata == 8'h02, "R11 released", ctl_rdata, 2);

        // R4: fast rate
        measure(lo_l, hi_l);
        chk(lo_l == H, "R4 low phase", lo_l, H);
        chk(hi_l == H, "R4 high phase", hi_l, H);

        // R5: slow rate
        wr(8'h06);
        repeat (40) @(negedge clk);
        measure(lo_l, hi_l);
        chk(lo_l == 2 * H, "R5 low phase", lo_l, 2 * H);
        chk(hi_l == 2 * H, "R5 high phase", hi_l, 2 * H);

        // R5: random toggling of the halve bit
        mon_on = 1'b1;
        for (int i = 0; i < 16; i++) begin
            wr(($urandom_range(0, 1) == 1) ? 8'h06 : 8'h02);
            repeat ($urandom_range(1, 30)) @(negedge clk);
        end
        repeat (40) @(negedge clk);
        mon_on = 1'b0;
        chk(mon_bad == 0, "R5 phase pairs", mon_bad, 0);
        chk(mon_n > 5, "R5 periods observed", mon_n, 6);

        // R6 R7 R8 R10 R11: random segments against reference state
        for (int i = 0; i < 120; i++) begin
            int pick;
            pick = $urandom_range(0, 11);
            if (pick == 0) wr(8'h00);
            else if (pick == 1) wr(8'h86);
            else if (pick < 4) wr(($urandom_range(0, 1) == 1) ? 8'h06 : 8'h02);
            scl_in = $urandom_range(0, 1);
            sda_in = ($urandom_range(0, 3) != 0);
            te_clr = ($urandom_range(0, 5) == 0);
            @(negedge clk);
            te_clr = 1'b0;
            repeat ($urandom_range(0, 60)) @(negedge clk);
            chk(te_stat == te_m, "R6 R7 random te", te_stat, te_m);
            chk(bus_idle == idle_m, "R8 R10 random idle", bus_idle, idle_m);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule